// File: doc/BRIEF.md
# PLL-aware system reset generator

This block creates the chip-wide system reset from three kinds of input: an active-low reset pin, the lock flags of the on-chip PLLs, and one lock flag from PLLs outside the chip. The system reset goes low at once, with no clock edge needed, whenever the pin goes low. It comes back high only on a clock edge, a fixed number of cycles after the pin is released, and only while every lock that counts is present. If a counted lock is lost during operation, the system reset goes low again. It is then released by the same sequence.

A PLL's lock does not count while that PLL is bypassed. The lock of the PLL that can feed the memory clock also does not count while the memory clock select picks the other source. A strap input is captured once after the pin is released. When that captured strap is high, all on-chip PLL locks are treated as present. The external lock is never masked. Every lock input passes through a two-flop synchroniser inside the block.

A second reset output serves strap sampling, the general register bank and the PLL reconfiguration logic. It depends only on the reset pin.

Top module: `sysrst_gen`

## Requirements
- R1: Both reset outputs go low asynchronously, within the same clock phase, when `ext_rst_n_i` goes low.
- R2: With all counted locks present and stable, `sys_rst_n_o` goes high exactly at the 7th rising clock edge after `ext_rst_n_i` rises. This is SYNC_STAGES (2) + 1 + REL_DELAY (4).
- R3: `sys_rst_n_o` stays low while any counted lock is low. If the master reset is already released, `sys_rst_n_o` goes high at the 6th rising edge after the last counted lock rises (SYNC_STAGES + REL_DELAY).
- R4: A counted lock falling while running drives `sys_rst_n_o` low at the 3rd rising edge after the fall. A lock lost while the release count is running restarts the count from zero.
- R5: `pll_bypass_i[i]` = 1 removes `pll_lock_i[i]` from the release condition.
- R6: `mem_clk_sel_i` = 1 removes the lock of PLL index MEM_IDX (default 2) from the release condition.
- R7: `ign_lock_strap_i` is captured at the first rising edge at which the master reset is already high. A captured 1 treats every `pll_lock_i` bit as present. Later changes of the strap have no effect until the next pin reset.
- R8: `ext_lock_i` low always keeps `sys_rst_n_o` low, whatever the strap, bypass and select inputs are.
- R9: `mst_rst_n_o` goes high at the 2nd rising edge after `ext_rst_n_i` rises. It stays high while the pin stays high, whatever the lock inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| ext_rst_n_i | input | 1 | External active-low reset pin |
| pll_lock_i | input | N_PLL | Lock flags of the on-chip PLLs (asynchronous) |
| pll_bypass_i | input | N_PLL | PLL bypass flags; 1 removes that lock from the release condition |
| mem_clk_sel_i | input | 1 | 1 = memory clock taken from the other source; removes the lock of PLL MEM_IDX |
| ext_lock_i | input | 1 | Lock flag of the external PLLs (asynchronous, never masked) |
| ign_lock_strap_i | input | 1 | Strap that ignores the on-chip lock flags; captured after master release |
| sys_rst_n_o | output | 1 | Active-low system reset |
| mst_rst_n_o | output | 1 | Active-low reset that follows the pin only |

## Verification
Two functions can fall in the same cycle: the release count advancing and a loss of lock. The bench restores a lock and lets the counter run part of the way. It then drops the lock again, so that the synchronised fall reaches the counter while it is still counting. The result is judged by the exact number of edges from the final restore to release: it must be the full 6, not a shortened one. An exhaustive sweep over lock, bypass, select, strap and external-lock values sets the qualification logic against a mask computed arithmetically in the bench.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

  // Edges from pin release until the system reset rises, when all locks are steady.
  function automatic int unsigned cold_release_edges(input int unsigned stages,
                                                     input int unsigned delay);
    return stages + 1 + delay;
  endfunction

  // Edges from the last counted lock rising until release, master already out.
  function automatic int unsigned relock_edges(input int unsigned stages,
                                               input int unsigned delay);
    return stages + delay;
  endfunction

  // Whether a single on-chip PLL lock takes part in the release condition.
  function automatic logic lock_counts(input logic bypass,
                                       input logic mem_desel,
                                       input logic ignore_all);
    return !(bypass || mem_desel || ignore_all);
  endfunction

endpackage

// File: rtl/sysrst_sync_chain.sv
module sysrst_sync_chain #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge arst_n_i) begin
          if (!arst_n_i) stage_q[s] <= '0;
          else           stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge arst_n_i) begin
          if (!arst_n_i) stage_q[s] <= '0;
          else           stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

  // R9: the output moves by one stage per edge; a rise needs the input held at least one edge
  a_r9_chain_order: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(q_o[0]) |-> $past(d_i[0]));

endmodule

// File: rtl/sysrst_lock_qual.sv
module sysrst_lock_qual
  import sysrst_pkg::*;
#(
  parameter int unsigned N_PLL   = 3,
  parameter int unsigned MEM_IDX = 2
) (
  input  logic [N_PLL-1:0] lock_s_i,
  input  logic [N_PLL-1:0] bypass_i,
  input  logic             mem_sel_i,
  input  logic             ignore_i,
  input  logic             ext_lock_s_i,
  output logic [N_PLL-1:0] counted_o,
  output logic             all_ok_o
);

  logic [N_PLL-1:0] pll_ok;

  generate
    for (genvar i = 0; i < N_PLL; i++) begin : g_pll
      if (i == MEM_IDX) begin : g_mem
        assign counted_o[i] = lock_counts(bypass_i[i], mem_sel_i, ignore_i);
      end else begin : g_plain
        assign counted_o[i] = lock_counts(bypass_i[i], 1'b0, ignore_i);
      end
      assign pll_ok[i] = lock_s_i[i] || !counted_o[i];
    end
  endgenerate

  assign all_ok_o = ext_lock_s_i && (&pll_ok);

endmodule

// File: rtl/sysrst_release_ctr.sv
module sysrst_release_ctr #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic cond_i,
  output logic rel_o
);

  localparam int unsigned CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          cnt_sat;
  logic          rel_q;

  assign cnt_sat = (cnt_q == CW'(DELAY));

  always_comb begin
    if (!cond_i)      cnt_nx = '0;
    else if (cnt_sat) cnt_nx = cnt_q;
    else              cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      rel_q <= (cnt_nx == CW'(DELAY));
    end
  end

  assign rel_o = rel_q;

  // R4: a false condition while released drops the release at the next edge
  a_r4_drop_on_loss: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    rel_q && !cond_i |=> !rel_q);

  // R2: the release can only rise after a cycle with the condition true
  a_r2_rise_after_cond: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(rel_q) |-> $past(cond_i));

  // R2: while released the count sits at its limit
  a_r2_released_saturated: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    rel_q |-> cnt_sat);

  // R4: a false condition always clears the count
  a_r4_count_restart: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !cond_i |=> cnt_q == '0);

endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen
  import sysrst_pkg::*;
#(
  parameter int unsigned N_PLL       = 3,
  parameter int unsigned MEM_IDX     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REL_DELAY   = 4
) (
  input  logic             clk_i,
  input  logic             ext_rst_n_i,
  input  logic [N_PLL-1:0] pll_lock_i,
  input  logic [N_PLL-1:0] pll_bypass_i,
  input  logic             mem_clk_sel_i,
  input  logic             ext_lock_i,
  input  logic             ign_lock_strap_i,
  output logic             sys_rst_n_o,
  output logic             mst_rst_n_o
);

  localparam int unsigned LOCK_W = N_PLL + 1;

  // named internal events for the assertions
  logic              mst_rel;
  logic [LOCK_W-1:0] lock_raw;
  logic [LOCK_W-1:0] lock_sync;
  logic [N_PLL-1:0]  pll_lock_s;
  logic              ext_lock_s;
  logic [N_PLL-1:0]  pll_counted;
  logic              lock_ok;
  logic              strap_q;
  logic              strap_done_q;
  logic              release_cond;
  logic              sys_rel;

  // master reset: pin only
  sysrst_sync_chain #(.STAGES(SYNC_STAGES), .WIDTH(1)) i_mst_sync (
    .clk_i   (clk_i),
    .arst_n_i(ext_rst_n_i),
    .d_i     (1'b1),
    .q_o     (mst_rel)
  );
  assign mst_rst_n_o = mst_rel;

  // lock synchronisers: on-chip locks plus the external one
  assign lock_raw = {ext_lock_i, pll_lock_i};

  sysrst_sync_chain #(.STAGES(SYNC_STAGES), .WIDTH(LOCK_W)) i_lock_sync (
    .clk_i   (clk_i),
    .arst_n_i(ext_rst_n_i),
    .d_i     (lock_raw),
    .q_o     (lock_sync)
  );
  assign pll_lock_s = lock_sync[N_PLL-1:0];
  assign ext_lock_s = lock_sync[N_PLL];

  // strap capture, once per pin reset
  always_ff @(posedge clk_i or negedge ext_rst_n_i) begin
    if (!ext_rst_n_i) begin
      strap_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q && mst_rel) begin
      strap_q      <= ign_lock_strap_i;
      strap_done_q <= 1'b1;
    end
  end

  sysrst_lock_qual #(.N_PLL(N_PLL), .MEM_IDX(MEM_IDX)) i_qual (
    .lock_s_i    (pll_lock_s),
    .bypass_i    (pll_bypass_i),
    .mem_sel_i   (mem_clk_sel_i),
    .ignore_i    (strap_q),
    .ext_lock_s_i(ext_lock_s),
    .counted_o   (pll_counted),
    .all_ok_o    (lock_ok)
  );

  assign release_cond = mst_rel && strap_done_q && lock_ok;

  sysrst_release_ctr #(.DELAY(REL_DELAY)) i_ctr (
    .clk_i   (clk_i),
    .arst_n_i(ext_rst_n_i),
    .cond_i  (release_cond),
    .rel_o   (sys_rel)
  );
  assign sys_rst_n_o = sys_rel;

  // R1: pin low means both outputs low (this property concerns the reset itself)
  a_r1_pin_forces_low: assert property (@(posedge clk_i)
    !ext_rst_n_i |-> !sys_rst_n_o && !mst_rst_n_o);

  // R9: once out, the master reset stays out while the pin stays high
  a_r9_master_steady: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    mst_rst_n_o |=> mst_rst_n_o);

  // R8: a missing external lock always holds the system in reset
  a_r8_ext_lock_kept: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    !ext_lock_s |=> !sys_rst_n_o);

  // R3: release only follows a cycle with every counted lock present
  a_r3_release_locked: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    $rose(sys_rst_n_o) |-> $past(lock_ok));

  // R7: the captured strap never changes until the next pin reset
  a_r7_strap_hold: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    strap_done_q |=> strap_done_q && $stable(strap_q));

  // R5: a bypassed PLL is never among the counted locks
  a_r5_bypass_uncounted: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    (pll_bypass_i & pll_counted) == '0);

endmodule

// File: tb/test_sysrst_gen.sv
module test_sysrst_gen;

  localparam int CLK_P   = 10;
  localparam int NP      = 3;
  localparam int MEMP    = 2;
  localparam int SYNC    = 2;
  localparam int DLY     = 4;
  localparam int COLD    = SYNC + 1 + DLY;  // 7
  localparam int RELOCK  = SYNC + DLY;      // 6

  logic          clk = 1'b0;
  logic          ext_rst_n = 1'b0;
  logic [NP-1:0] lock = '0;
  logic [NP-1:0] byp = '0;
  logic          msel = 1'b0;
  logic          elock = 1'b0;
  logic          strap = 1'b0;
  logic          sys_n;
  logic          mst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sysrst_gen #(.N_PLL(NP), .MEM_IDX(MEMP), .SYNC_STAGES(SYNC), .REL_DELAY(DLY)) i_sysrst_gen (
    .clk_i           (clk),
    .ext_rst_n_i     (ext_rst_n),
    .pll_lock_i      (lock),
    .pll_bypass_i    (byp),
    .mem_clk_sel_i   (msel),
    .ext_lock_i      (elock),
    .ign_lock_strap_i(strap),
    .sys_rst_n_o     (sys_n),
    .mst_rst_n_o     (mst_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pin low, then release at a negedge; returns edges until sys and master rise
  task automatic pin_cycle(output int sys_at, output int mst_at);
    @(negedge clk);
    ext_rst_n = 1'b0;
    edges(2);
    ext_rst_n = 1'b1;
    sys_at = 0;
    mst_at = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (sys_n && sys_at == 0) sys_at = k;
      if (mst_n && mst_at == 0) mst_at = k;
    end
  endtask

  function automatic bit expect_ok(input logic [NP-1:0] l, input logic [NP-1:0] b,
                                   input logic s, input logic st, input logic e);
    bit ok = e;
    for (int i = 0; i < NP; i++) begin
      bit masked = b[i] || st || (i == MEMP && s);
      if (!masked && !l[i]) ok = 0;
    end
    return ok;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s_at;
    int m_at;
    // reset state
    #1;
    chk("R1 reset sys", sys_n, 0);
    chk("R1 reset mst", mst_n, 0);

    // R2, R9: cold release timing with all locks steady
    lock = '1; elock = 1'b1;
    pin_cycle(s_at, m_at);
    chk("R2 cold release edge", s_at, COLD);
    chk("R9 master release edge", m_at, SYNC);

    // R1: asynchronous assertion in the middle of the high clock phase
    @(posedge clk); #2;
    ext_rst_n = 1'b0;
    #1;
    chk("R1 async sys mid-cycle", sys_n, 0);
    chk("R1 async mst mid-cycle", mst_n, 0);

    // R4: loss of lock while running
    pin_cycle(s_at, m_at);
    chk("R4 running before loss", sys_n, 1);
    lock[0] = 1'b0;
    edges(2);
    chk("R4 still high 2 edges after loss", sys_n, 1);
    edges(1);
    chk("R4 low 3 edges after loss", sys_n, 0);
    chk("R9 master unaffected by loss", mst_n, 1);
    // R3: relock timing
    lock[0] = 1'b1;
    s_at = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (sys_n && s_at == 0) s_at = k;
    end
    chk("R3 relock release edge", s_at, RELOCK);

    // R4: loss during the count restarts it
    lock[0] = 1'b0;
    edges(6);
    lock[0] = 1'b1;
    edges(3);
    lock[0] = 1'b0;
    edges(2);
    chk("R4 low during interrupted count", sys_n, 0);
    lock[0] = 1'b1;
    s_at = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (sys_n && s_at == 0) s_at = k;
    end
    chk("R4 count restarted after interruption", s_at, RELOCK);

    // R5: bypassed PLL with lock low does not hold reset, released on time
    byp = 3'b010; lock = 3'b101;
    pin_cycle(s_at, m_at);
    chk("R5 bypassed low lock release edge", s_at, COLD);

    // R7: strap captured, later change ignored
    byp = '0; lock = '0; strap = 1'b1;
    pin_cycle(s_at, m_at);
    chk("R7 strap masks locks", sys_n, 1);
    strap = 1'b0;
    edges(6);
    chk("R7 strap change ignored", sys_n, 1);
    // R8: external lock honoured despite strap
    elock = 1'b0;
    edges(3);
    chk("R8 ext lock loss with strap", sys_n, 0);

    // exhaustive sweep: R3 R5 R6 R7 R8 R9
    for (int v = 0; v < 512; v++) begin
      lock  = v[2:0];
      byp   = v[5:3];
      msel  = v[6];
      strap = v[7];
      elock = v[8];
      pin_cycle(s_at, m_at);
      chk($sformatf("R3/R5/R6/R7/R8 sweep v=%0d", v), sys_n,
          int'(expect_ok(lock, byp, msel, strap, elock)));
      chk($sformatf("R9 sweep master v=%0d", v), mst_n, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule